// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one IEEE-754 binary floating-point operand and returns the nearest integral value in the same format, chosen by a rounding mode. A parameter selects single or double precision. Each operation comes with an 8-bit immediate. The immediate either names a rounding mode itself or defers to a small rounding-mode control register. One of its bits also hides the precision (inexact) flag. Results and a 6-bit exception flag vector come out of one output register stage.

Signalling NaNs are turned into quiet NaNs and always raise the invalid flag, whatever the immediate says. Zeros, infinities, quiet NaNs and operands that are already integral come back unchanged and raise no flag. When a magnitude below one rounds to zero, the result keeps the operand's sign, so negative inputs can give -0.0.

Top module: `rti_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_flags` is 0, and the rounding-mode control register holds round-to-nearest-even (code 00).
- R2: A result and its flags appear on the outputs exactly one clock after `in_valid` is sampled high. `out_valid` is high in that cycle and low in the cycle after a clock where `in_valid` was low.
- R3: When immediate bit 2 is 1, the mode comes from the control register, which `ctl_wr` loads from `ctl_mode` at a clock edge. When bit 2 is 0, immediate bits 1:0 give the mode: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. Immediate bits 7:4 have no effect.
- R4: In nearest-even mode, a fraction of exactly one half rounds to the even integer, and any other fraction rounds to the nearer integer.
- R5: The down, up and toward-zero modes give floor, ceiling and truncation. This includes a carry that raises the exponent (for example, 2^52 - 0.5 rounded up gives 2^52).
- R6: A nonzero operand that rounds to zero returns a zero with the operand's sign.
- R7: Flag bit 5 (precision) is set when the result differs from the operand, unless immediate bit 3 is 1, in which case it stays 0. The smallest normal number gives flags 0x20 with immediate 4 and 0x00 with immediate 12.
- R8: A signalling NaN (all-ones exponent, fraction MSB 0, fraction nonzero) returns the same sign and payload with the fraction MSB set. It raises flag bit 0 (invalid) for every immediate, including immediate 12.
- R9: Zeros, infinities, quiet NaNs and integral operands are returned bit-for-bit unchanged with flags 0x00.
- R10: Flag bits 4:1 are always 0, and `out_flags` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_op | input | W (32 or 64) | Operand bits |
| in_imm | input | 8 | Immediate control field |
| ctl_wr | input | 1 | Load the rounding-mode control register |
| ctl_mode | input | 2 | New control-register mode |
| out_valid | output | 1 | Result valid |
| out_res | output | W | Rounded result |
| out_flags | output | 6 | Exception flags: bit 0 invalid, bit 5 precision |

## Verification
Every result and its flags are due one clock after the edge that samples `in_valid`. The bench drives each operand on a falling edge and compares on the next falling edge, after exactly one rising edge, against a model built on real-number floor and ceiling. A control-register write takes effect at the edge that samples `ctl_wr`, so the bench issues dependent operations only after that edge. Idle cycles are checked one clock after `in_valid` drops.

// File: rtl/rti_pkg.sv
package rti_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rti_rmode_e;

   typedef enum logic [2:0] {
      CL_ZERO,
      CL_INF,
      CL_QNAN,
      CL_SNAN,
      CL_FRAC,
      CL_MID,
      CL_BIG
   } rti_class_e;

   localparam int FLG_W    = 6;
   localparam int FLG_INV  = 0;
   localparam int FLG_PREC = 5;
   localparam int IMM_DYN  = 2;
   localparam int IMM_NOPE = 3;
endpackage

// File: rtl/rti_mode_sel.sv
module rti_mode_sel
   import rti_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [1:0] ctl_mode,
   input  logic       use_ctl,
   input  logic [1:0] imm_mode,
   output rti_rmode_e eff_mode
);
   rti_rmode_e ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl_q <= RM_NEAR;
      else if (ctl_wr)
         ctl_q <= rti_rmode_e'(ctl_mode);
   end

   always_comb eff_mode = use_ctl ? ctl_q : rti_rmode_e'(imm_mode);
endmodule

// File: rtl/rti_classify.sv
module rti_classify
   import rti_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int NF_W   = 6,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]    op,
   output rti_class_e      cls,
   output logic [NF_W-1:0] nfrac
);
   localparam logic [EXP_W-1:0] BIAS_E = EXP_W'((1 << (EXP_W - 1)) - 1);
   localparam logic [EXP_W-1:0] BIG_E  = EXP_W'((1 << (EXP_W - 1)) - 1 + FRAC_W);

   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;
   logic [EXP_W-1:0]  diff;

   assign ex    = op[W-2:FRAC_W];
   assign fr    = op[FRAC_W-1:0];
   assign diff  = BIG_E - ex;
   assign nfrac = diff[NF_W-1:0];

   always_comb begin
      if (&ex)
         cls = (fr == '0) ? CL_INF : (fr[FRAC_W-1] ? CL_QNAN : CL_SNAN);
      else if (ex == '0 && fr == '0)
         cls = CL_ZERO;
      else if (ex < BIAS_E)
         cls = CL_FRAC;
      else if (ex >= BIG_E)
         cls = CL_BIG;
      else
         cls = CL_MID;
   end
endmodule

// File: rtl/rti_round_core.sv
module rti_round_core
   import rti_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int NF_W   = 6,
   localparam int W     = 1 + EXP_W + FRAC_W,
   localparam int M_W   = FRAC_W + 1
) (
   input  logic [W-1:0]    op,
   input  rti_class_e      cls,
   input  logic [NF_W-1:0] nfrac,
   input  rti_rmode_e      mode,
   output logic [W-1:0]    res,
   output logic            inexact,
   output logic            invalid
);
   localparam logic [EXP_W-1:0] BIAS_E  = EXP_W'((1 << (EXP_W - 1)) - 1);
   localparam logic [EXP_W-1:0] HALF_E  = EXP_W'((1 << (EXP_W - 1)) - 2);

   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;
   logic [M_W-1:0]    mant, mask, fpart, ipart, half, unit;
   logic [M_W:0]      sum;
   logic              lsb_int, inc_mid, inc_frac;

   assign sgn  = op[W-1];
   assign ex   = op[W-2:FRAC_W];
   assign fr   = op[FRAC_W-1:0];
   assign mant = {1'b1, fr};

   // one mask bit per mantissa position below the binary point
   for (genvar i = 0; i < M_W; i++) begin : g_mask
      assign mask[i] = (32'(i) < 32'(nfrac));
   end

   assign fpart   = mant & mask;
   assign ipart   = mant & ~mask;
   assign half    = (mask >> 1) + M_W'(1);
   assign unit    = mask + M_W'(1);
   assign lsb_int = |(ipart & unit);

   always_comb begin
      unique case (mode)
         RM_NEAR: inc_mid = (fpart > half) || (fpart == half && lsb_int);
         RM_DOWN: inc_mid = sgn;
         RM_UP:   inc_mid = !sgn;
         default: inc_mid = 1'b0;
      endcase
      unique case (mode)
         RM_NEAR: inc_frac = (ex == HALF_E) && (fr != '0);
         RM_DOWN: inc_frac = sgn;
         RM_UP:   inc_frac = !sgn;
         default: inc_frac = 1'b0;
      endcase
   end

   assign sum = {1'b0, ipart} + (inc_mid ? {1'b0, unit} : '0);

   always_comb begin
      res     = op;
      inexact = 1'b0;
      invalid = 1'b0;
      unique case (cls)
         CL_SNAN: begin
            res[FRAC_W-1] = 1'b1;
            invalid       = 1'b1;
         end
         CL_FRAC: begin
            inexact = 1'b1;
            res     = inc_frac ? {sgn, BIAS_E, {FRAC_W{1'b0}}} : {sgn, {(W-1){1'b0}}};
         end
         CL_MID: begin
            if (fpart != '0) begin
               inexact = 1'b1;
               if (sum[M_W])
                  res = {sgn, ex + EXP_W'(1), {FRAC_W{1'b0}}};
               else
                  res = {sgn, ex, sum[FRAC_W-1:0]};
            end
         end
         default: res = op;
      endcase
   end
endmodule

// File: rtl/rti_unit.sv
module rti_unit
   import rti_pkg::*;
#(
   parameter int FMT_DOUBLE = 1,
   localparam int EXP_W     = (FMT_DOUBLE != 0) ? 11 : 8,
   localparam int FRAC_W    = (FMT_DOUBLE != 0) ? 52 : 23,
   localparam int W         = 1 + EXP_W + FRAC_W,
   localparam int NF_W      = $clog2(FRAC_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_op,
   input  logic [7:0]       in_imm,
   input  logic             ctl_wr,
   input  logic [1:0]       ctl_mode,
   output logic             out_valid,
   output logic [W-1:0]     out_res,
   output logic [FLG_W-1:0] out_flags
);
   if (FMT_DOUBLE != 0 && FMT_DOUBLE != 1) begin : g_bad_fmt
      $error("rti_unit: FMT_DOUBLE must be 0 or 1");
   end
   if ((1 << NF_W) <= FRAC_W) begin : g_bad_nf
      $error("rti_unit: fraction count field too narrow");
   end

   rti_rmode_e        mode;
   rti_class_e        cls;
   logic [NF_W-1:0]   nfrac;
   logic [W-1:0]      res;
   logic              inexact, invalid;
   logic [FLG_W-1:0]  flags;

   rti_mode_sel u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_mode (ctl_mode),
      .use_ctl  (in_imm[IMM_DYN]),
      .imm_mode (in_imm[1:0]),
      .eff_mode (mode)
   );

   rti_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .NF_W(NF_W)) u_cls (
      .op    (in_op),
      .cls   (cls),
      .nfrac (nfrac)
   );

   rti_round_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .NF_W(NF_W)) u_core (
      .op      (in_op),
      .cls     (cls),
      .nfrac   (nfrac),
      .mode    (mode),
      .res     (res),
      .inexact (inexact),
      .invalid (invalid)
   );

   always_comb begin
      flags           = '0;
      flags[FLG_INV]  = invalid;
      flags[FLG_PREC] = inexact && !in_imm[IMM_NOPE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         out_flags <= '0;
      end else begin
         out_valid <= in_valid;
         out_flags <= in_valid ? flags : '0;
         if (in_valid)
            out_res <= res;
      end
   end
endmodule

// File: rtl/rti_unit_chk.sv
module rti_unit_chk #(
   parameter int W      = 64,
   parameter int FRAC_W = 52
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [W-1:0] in_op,
   input logic [7:0]   in_imm,
   input logic         out_valid,
   input logic [W-1:0] out_res,
   input logic [5:0]   out_flags
);
   logic in_allone, in_snan, in_inf;
   assign in_allone = &in_op[W-2:FRAC_W];
   assign in_snan   = in_allone && !in_op[FRAC_W-1] && (in_op[FRAC_W-2:0] != '0);
   assign in_inf    = in_allone && (in_op[FRAC_W-1:0] == '0);

   a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r10_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_flags == 6'd0);
   a_r10_flags_unused: assert property (@(posedge clk) disable iff (!rst_n)
      out_flags[4:1] == 4'd0);
   a_r7_prec_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_imm[3]) |=> !out_flags[5]);
   a_r8_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_snan) |=> (out_flags[0] && out_res[FRAC_W-1]));
   a_r9_inf_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_inf) |=> (out_res == $past(in_op) && out_flags == 6'd0));
endmodule

bind rti_unit rti_unit_chk #(.W(W), .FRAC_W(FRAC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_imm    (in_imm),
   .out_valid (out_valid),
   .out_res   (out_res),
   .out_flags (out_flags)
);

// File: tb/tb_rti_unit.sv
`timescale 1ns/1ps
module tb_rti_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic [7:0]  in_imm = '0;
   logic        ctl_wr = 1'b0;
   logic [1:0]  ctl_mode = '0;
   logic        out_valid;
   logic [63:0] out_res;
   logic [5:0]  out_flags;

   int checks = 0;
   int errors = 0;
   logic [1:0] bench_ctl = 2'b00;

   always #2.5 clk = ~clk;

   rti_unit #(.FMT_DOUBLE(1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_imm(in_imm),
      .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .out_valid(out_valid), .out_res(out_res),
      .out_flags(out_flags)
   );

   function automatic void model(input logic [63:0] op, input logic [7:0] imm,
                                 input logic [1:0] cm, output logic [63:0] r,
                                 output logic [5:0] f);
      logic [1:0] m;
      real x, y, d;
      m = imm[2] ? cm : imm[1:0];
      f = '0;
      if (op[62:52] == 11'h7FF) begin
         r = op;
         if (op[51:0] != 0 && !op[51]) begin
            r[51] = 1'b1;
            f[0]  = 1'b1;
         end
         return;
      end
      x = $bitstoreal(op);
      case (m)
         2'b00: begin
            y = $floor(x);
            d = x - y;
            if (d > 0.5 || (d == 0.5 && $floor(y / 2.0) * 2.0 != y)) y = y + 1.0;
         end
         2'b01: y = $floor(x);
         2'b10: y = $ceil(x);
         default: y = (x < 0.0) ? $ceil(x) : $floor(x);
      endcase
      if (y == 0.0) r = {op[63], 63'd0};
      else          r = $realtobits(y);
      if (y != x) f[5] = !imm[3];
   endfunction

   task automatic check(input string tag, input logic ok, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [63:0] op, input logic [7:0] imm);
      logic [63:0] er;
      logic [5:0]  ef;
      model(op, imm, bench_ctl, er, ef);
      in_valid = 1'b1;
      in_op    = op;
      in_imm   = imm;
      @(negedge clk);
      check({tag, " valid"}, out_valid === 1'b1, {63'd0, out_valid}, 64'd1);
      check({tag, " result"}, out_res === er, out_res, er);
      check({tag, " flags"}, out_flags === ef, {58'd0, out_flags}, {58'd0, ef});
      in_valid = 1'b0;
   endtask

   task automatic set_ctl(input logic [1:0] m);
      ctl_wr   = 1'b1;
      ctl_mode = m;
      @(negedge clk);
      ctl_wr    = 1'b0;
      bench_ctl = m;
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 reset valid", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);
      check("R1 reset flags", out_flags === 6'd0, {58'd0, out_flags}, 64'd0);
      // R1: control register resets to nearest-even
      run("R1 ctl default tie", $realtobits(2.5), 8'h04);
      run("R1 ctl default up", $realtobits(2.7), 8'h04);

      // R7: precision flag and its suppression
      run("R7 min normal imm4", 64'h0010_0000_0000_0000, 8'h04);
      run("R7 min normal imm12", 64'h0010_0000_0000_0000, 8'h0C);
      run("R7 suppressed mid", $realtobits(3.25), 8'h08);

      // R8: signalling NaN
      run("R8 snan imm4", 64'h7FF0_0000_0000_0001, 8'h04);
      run("R8 snan imm12", 64'h7FF0_0000_0000_0001, 8'h0C);
      run("R8 neg snan payload", 64'hFFF4_0000_0ABC_0000, 8'h0B);

      // R9: pass-through
      run("R9 qnan", 64'h7FF8_0000_0000_0123, 8'h00);
      run("R9 pos inf", 64'h7FF0_0000_0000_0000, 8'h02);
      run("R9 neg inf", 64'hFFF0_0000_0000_0000, 8'h01);
      run("R9 neg zero", 64'h8000_0000_0000_0000, 8'h02);
      run("R9 big integral", $realtobits(1.0e20), 8'h00);
      run("R9 small integral", $realtobits(-7.0), 8'h01);

      // R4: nearest-even
      run("R4 3.5", $realtobits(3.5), 8'h00);
      run("R4 2.5", $realtobits(2.5), 8'h00);
      run("R4 -2.5", $realtobits(-2.5), 8'h00);
      run("R4 0.5", $realtobits(0.5), 8'h00);
      run("R4 0.75", $realtobits(0.75), 8'h00);
      run("R4 2^51+0.5", $realtobits(2251799813685248.5), 8'h00);

      // R5: directed modes
      run("R5 1.5 down", $realtobits(1.5), 8'h01);
      run("R5 1.5 up", $realtobits(1.5), 8'h02);
      run("R5 1.5 zero", $realtobits(1.5), 8'h03);
      run("R5 -1.5 down", $realtobits(-1.5), 8'h01);
      run("R5 -1.5 zero", $realtobits(-1.5), 8'h03);
      run("R5 carry exp", $realtobits(4503599627370495.5), 8'h02);

      // R6: signed zero results
      run("R6 -0.3 up", $realtobits(-0.3), 8'h02);
      run("R6 -0.3 near", $realtobits(-0.3), 8'h00);
      run("R6 0.3 down", $realtobits(0.3), 8'h01);
      run("R6 -0.7 down", $realtobits(-0.7), 8'h01);
      run("R6 -denorm zero", 64'h8000_0000_0000_0005, 8'h03);

      // R3: mode source selection
      set_ctl(2'b10);
      run("R3 dyn up", $realtobits(1.2), 8'h04);
      run("R3 static overrides", $realtobits(1.2), 8'h00);
      set_ctl(2'b11);
      run("R3 dyn zero", $realtobits(-1.7), 8'h04);
      run("R3 high imm bits", $realtobits(1.5), 8'hF0);
      set_ctl(2'b01);
      run("R3 dyn down", $realtobits(-0.2), 8'h04);

      // R2: back-to-back then idle
      in_valid = 1'b1;
      in_op    = $realtobits(9.5);
      in_imm   = 8'h00;
      @(negedge clk);
      check("R2 b2b first", out_res === $realtobits(10.0), out_res, $realtobits(10.0));
      in_op = $realtobits(-9.5);
      @(negedge clk);
      check("R2 b2b second", out_res === $realtobits(-10.0), out_res, $realtobits(-10.0));
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 idle valid", out_valid === 1'b0, {63'd0, out_valid}, 64'd0);
      check("R10 idle flags", out_flags === 6'd0, {58'd0, out_flags}, 64'd0);

      // mixed patterns across all requirements
      for (int k = 0; k < 400; k++) begin
         logic [63:0] op;
         logic [7:0]  imm;
         logic [10:0] e;
         e  = 11'(1023 - 3 + $urandom_range(0, 58));
         op = {1'($urandom), e, 20'($urandom), 32'($urandom)};
         imm = 8'($urandom_range(0, 255));
         if (k % 50 == 0) set_ctl(2'($urandom));
         run("R5 random", op, imm);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule